// File: doc/BRIEF.md
# Processor Power-Mode and System-Management Sequencer

This block follows the operating context of a processor core and keeps that state for the rest of the core. It has eight modes: ordinary software, interrupt service entered from ordinary software, the system-management service routine, interrupt service entered from that routine, and four suspend modes. Suspend can start from a halt instruction or from the external suspend request pin, in either the ordinary or the system-management context. The instruction decoder sends it one-cycle strobes for halt, interrupt return, system-management entry and resume. The asynchronous pins (suspend request, system-management request, NMI and INTR) pass through a synchronizer chain and an edge detector before they have any effect.

Each NMI, INTR or system-management request is stored in a pending flag. The sequencer serves these flags in a fixed priority and sends a one-cycle start pulse for the service routine it opens. The suspend acknowledge output is low in every suspend mode. Instruction decode, the saving and restoring of state, and clock gating belong to other blocks.

Top module: `pwrmode_ctrl`

## Requirements
- R1: While reset is active, and after reset is released, the mode is 0 (ordinary software), all three pending flags are 0, all start pulses are 0 and the acknowledge is 1. Reset also clears the synchronizers.
- R2: Mode codes: 0 ordinary, 1 interrupt service from ordinary, 2 halt suspend from ordinary, 3 pin suspend from ordinary, 4 management routine, 5 interrupt service from management, 6 halt suspend from management, 7 pin suspend from management. `susp_ack_n_o` is 0 exactly when mode bit 1 is set.
- R3: In mode 0 or mode 4, a synchronized low suspend request moves the machine to the pin suspend of that context (3 or 7). Otherwise a halt strobe moves it to the halt suspend (2 or 6) at the next edge. In mode 0 the pending services are handled before either of these.
- R4: Mode 2 wakes on a pending management request into mode 4 with `smm_start_o`. Otherwise it wakes on a pending NMI, then a pending INTR, into mode 1 with the matching start pulse.
- R5: Mode 3 stays in mode 3 while the synchronized suspend request is low, and it keeps latching events. It returns to mode 0 when the request goes high.
- R6: In mode 0, the entry strobe or a pending management request moves the machine to mode 4 with `smm_start_o`. A resume strobe in mode 4 returns it to mode 0.
- R7: An interrupt-return strobe moves mode 1 to mode 0 and mode 5 to mode 4.
- R8: A rising INTR edge is latched only if `if_i` is 1 in the cycle in which the synchronized edge appears.
- R9: In mode 0 the order of service is management request, then NMI, then INTR. At most one start pulse is high in any cycle.
- R10: A pending flag clears in the cycle its start pulse is issued. A new edge in that same cycle sets the flag again. Entering mode 4 clears the management flag.
- R11: A falling management-request edge is not latched while mode bit 2 is set.
- R12: Modes 4 and 7 latch NMI and INTR but do not serve them. Mode 6 wakes on a pending NMI, then a pending INTR, into mode 5 with the matching start pulse.
- R13: An asynchronous pin change reaches the synchronized value after SYNC_STAGES edges. A pending flag sets one edge after that, and a mode change follows on the next edge. A strobe acts at the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Halt instruction strobe |
| iret_i | input | 1 | Interrupt-return instruction strobe |
| smm_enter_i | input | 1 | Management-entry instruction strobe |
| resume_i | input | 1 | Resume-from-management instruction strobe |
| susp_n_i | input | 1 | Asynchronous suspend request, active low |
| smi_n_i | input | 1 | Asynchronous management request, active low, falling edge |
| nmi_i | input | 1 | Asynchronous NMI, rising edge |
| intr_i | input | 1 | Asynchronous maskable interrupt, rising edge |
| if_i | input | 1 | Interrupt-enable flag |
| susp_ack_n_o | output | 1 | Suspend acknowledge, active low |
| mode_o | output | 3 | Current mode code (R2) |
| smi_pend_o | output | 1 | Management request pending |
| nmi_pend_o | output | 1 | NMI pending |
| intr_pend_o | output | 1 | INTR pending |
| smm_start_o | output | 1 | Management routine start pulse |
| nmi_start_o | output | 1 | NMI service start pulse |
| intr_start_o | output | 1 | INTR service start pulse |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. Every pin-driven check must then land exactly one cycle later than it would at the default depth, so a synchronizer chain that ignores the parameter shows up at once. With the deeper chain, short random pin pulses more often overlap strobes and mode changes, which exercises the cases where an edge arrives in the same cycle as a clear and where a management request arrives in the same cycle as an entry into the management context.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;
  typedef enum logic [2:0] {
    MODE_NORM   = 3'd0,
    MODE_ISR_N  = 3'd1,
    MODE_HALT_N = 3'd2,
    MODE_PIN_N  = 3'd3,
    MODE_SMM    = 3'd4,
    MODE_ISR_S  = 3'd5,
    MODE_HALT_S = 3'd6,
    MODE_PIN_S  = 3'd7
  } mode_e;

  // pin vector order; the first three double as event indices
  localparam int unsigned N_PINS   = 4;
  localparam int unsigned N_EV     = 3;
  localparam int unsigned EV_INTR  = 0;
  localparam int unsigned EV_NMI   = 1;
  localparam int unsigned EV_SMI   = 2;
  localparam int unsigned PIN_SUSP = 3;
  localparam logic [N_PINS-1:0] PIN_IDLE = 4'b1100;
endpackage

// File: rtl/pwrmode_sync.sv
module pwrmode_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwrmode_latch.sv
module pwrmode_latch
  import pwrmode_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev_pins_i,
  input  logic            if_i,
  input  logic            smm_ctx_i,
  input  logic [N_EV-1:0] clr_i,
  output logic [N_EV-1:0] pend_o
);
  logic [N_EV-1:0] prev_q;
  logic [N_EV-1:0] set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PIN_IDLE[N_EV-1:0];
    else        prev_q <= ev_pins_i;
  end

  always_comb begin
    set[EV_SMI]  = prev_q[EV_SMI] & ~ev_pins_i[EV_SMI] & ~smm_ctx_i;
    set[EV_NMI]  = ev_pins_i[EV_NMI] & ~prev_q[EV_NMI];
    set[EV_INTR] = ev_pins_i[EV_INTR] & ~prev_q[EV_INTR] & if_i;
  end

  for (genvar e = 0; e < N_EV; e++) begin : g_ev
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= (flag_q & ~clr_i[e]) | set[e];
    end
    assign pend_o[e] = flag_q;
  end

  // R8: masked INTR edges never raise the flag
  p_intr_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_i && !pend_o[EV_INTR]) |=> !pend_o[EV_INTR]);
  // R11: no management request latched in management context
  p_smi_ctx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (smm_ctx_i && !pend_o[EV_SMI]) |=> !pend_o[EV_SMI]);
  // R10: a served NMI flag drops unless a new edge arrives
  p_clear_nmi_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i[EV_NMI] && !set[EV_NMI]) |=> !pend_o[EV_NMI]);
endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
  import pwrmode_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_i,
  input  logic            iret_i,
  input  logic            smm_enter_i,
  input  logic            resume_i,
  input  logic            susp_hi_i,
  input  logic [N_EV-1:0] pend_i,
  output mode_e           state_o,
  output logic [N_EV-1:0] start_o,
  output logic [N_EV-1:0] clr_o
);
  mode_e           state_q, state_d;
  logic [N_EV-1:0] start_q, start_d;

  always_comb begin
    state_d = state_q;
    start_d = '0;
    unique case (state_q)
      MODE_NORM: begin
        if (smm_enter_i || pend_i[EV_SMI]) begin
          state_d = MODE_SMM;   start_d[EV_SMI] = 1'b1;
        end else if (pend_i[EV_NMI]) begin
          state_d = MODE_ISR_N; start_d[EV_NMI] = 1'b1;
        end else if (pend_i[EV_INTR]) begin
          state_d = MODE_ISR_N; start_d[EV_INTR] = 1'b1;
        end else if (!susp_hi_i) begin
          state_d = MODE_PIN_N;
        end else if (halt_i) begin
          state_d = MODE_HALT_N;
        end
      end
      MODE_ISR_N:  if (iret_i) state_d = MODE_NORM;
      MODE_HALT_N: begin
        if (pend_i[EV_SMI]) begin
          state_d = MODE_SMM;   start_d[EV_SMI] = 1'b1;
        end else if (pend_i[EV_NMI]) begin
          state_d = MODE_ISR_N; start_d[EV_NMI] = 1'b1;
        end else if (pend_i[EV_INTR]) begin
          state_d = MODE_ISR_N; start_d[EV_INTR] = 1'b1;
        end
      end
      MODE_PIN_N:  if (susp_hi_i) state_d = MODE_NORM;
      MODE_SMM: begin
        if (resume_i)        state_d = MODE_NORM;
        else if (!susp_hi_i) state_d = MODE_PIN_S;
        else if (halt_i)     state_d = MODE_HALT_S;
      end
      MODE_ISR_S:  if (iret_i) state_d = MODE_SMM;
      MODE_HALT_S: begin
        if (pend_i[EV_NMI]) begin
          state_d = MODE_ISR_S; start_d[EV_NMI] = 1'b1;
        end else if (pend_i[EV_INTR]) begin
          state_d = MODE_ISR_S; start_d[EV_INTR] = 1'b1;
        end
      end
      MODE_PIN_S:  if (susp_hi_i) state_d = MODE_SMM;
      default:     state_d = MODE_NORM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_NORM;
      start_q <= '0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
    end
  end

  assign state_o = state_q;
  assign start_o = start_q;
  assign clr_o   = start_d;

  // R9: a single service start per cycle
  p_one_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_q));
  // R7: interrupt return goes back to the originating context
  p_iret_smm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_ISR_S && iret_i) |=> state_q == MODE_SMM);
  p_iret_norm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_ISR_N && iret_i) |=> state_q == MODE_NORM);
  // R6: resume leaves the management routine
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_SMM && resume_i) |=> state_q == MODE_NORM);
  // R4: a pending management request wakes halt suspend into the routine
  p_halt_smi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_HALT_N && pend_i[EV_SMI]) |=> (state_q == MODE_SMM && start_q[EV_SMI]));
  // R5: pin suspend holds while the request is low
  p_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MODE_PIN_N && !susp_hi_i) |=> state_q == MODE_PIN_N);
endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
  import pwrmode_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_i,
  input  logic       iret_i,
  input  logic       smm_enter_i,
  input  logic       resume_i,
  input  logic       susp_n_i,
  input  logic       smi_n_i,
  input  logic       nmi_i,
  input  logic       intr_i,
  input  logic       if_i,
  output logic       susp_ack_n_o,
  output logic [2:0] mode_o,
  output logic       smi_pend_o,
  output logic       nmi_pend_o,
  output logic       intr_pend_o,
  output logic       smm_start_o,
  output logic       nmi_start_o,
  output logic       intr_start_o
);
  logic [N_PINS-1:0] pins_raw, pins_s;
  logic [N_EV-1:0]   pend, start, clr;
  mode_e             mode;

  assign pins_raw[PIN_SUSP] = susp_n_i;
  assign pins_raw[EV_SMI]   = smi_n_i;
  assign pins_raw[EV_NMI]   = nmi_i;
  assign pins_raw[EV_INTR]  = intr_i;

  pwrmode_sync #(
    .WIDTH  (N_PINS),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pins_raw),
    .q_o  (pins_s)
  );

  pwrmode_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_pins_i(pins_s[N_EV-1:0]),
    .if_i     (if_i),
    .smm_ctx_i(mode[2]),
    .clr_i    (clr),
    .pend_o   (pend)
  );

  pwrmode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_i     (halt_i),
    .iret_i     (iret_i),
    .smm_enter_i(smm_enter_i),
    .resume_i   (resume_i),
    .susp_hi_i  (pins_s[PIN_SUSP]),
    .pend_i     (pend),
    .state_o    (mode),
    .start_o    (start),
    .clr_o      (clr)
  );

  assign mode_o       = mode;
  assign susp_ack_n_o = ~mode[1];
  assign smi_pend_o   = pend[EV_SMI];
  assign nmi_pend_o   = pend[EV_NMI];
  assign intr_pend_o  = pend[EV_INTR];
  assign smm_start_o  = start[EV_SMI];
  assign nmi_start_o  = start[EV_NMI];
  assign intr_start_o = start[EV_INTR];
endmodule

// File: tb/test_pwrmode_ctrl.sv
`timescale 1ns/1ps
module test_pwrmode_ctrl;
  localparam int SYNC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_halt = 0, b_iret = 0, b_enter = 0, b_resume = 0;
  logic b_susp_n = 1, b_smi_n = 1, b_nmi = 0, b_intr = 0, b_if = 0;
  logic       ack_n, smi_p, nmi_p, intr_p, smm_st, nmi_st, intr_st;
  logic [2:0] mode;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwrmode_ctrl #(.SYNC_STAGES(SYNC)) i_pwrmode_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_i(b_halt), .iret_i(b_iret),
    .smm_enter_i(b_enter), .resume_i(b_resume), .susp_n_i(b_susp_n),
    .smi_n_i(b_smi_n), .nmi_i(b_nmi), .intr_i(b_intr), .if_i(b_if),
    .susp_ack_n_o(ack_n), .mode_o(mode), .smi_pend_o(smi_p),
    .nmi_pend_o(nmi_p), .intr_pend_o(intr_p), .smm_start_o(smm_st),
    .nmi_start_o(nmi_st), .intr_start_o(intr_st)
  );

  // requirement-level reference: pend/start bit 2 smi, 1 nmi, 0 intr
  logic [3:0] m_sync [SYNC];
  logic [2:0] m_prev, m_pend, m_start, m_state;

  always @(posedge clk or negedge rst_n) begin
    logic [3:0] s;
    logic [2:0] set, st, nx;
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) m_sync[i] = 4'b1100;
      m_prev = 3'b100; m_pend = 0; m_start = 0; m_state = 0;
    end else begin
      s = m_sync[SYNC-1];
      set[2] = m_prev[2] & ~s[2] & ~m_state[2];
      set[1] = s[1] & ~m_prev[1];
      set[0] = s[0] & ~m_prev[0] & b_if;
      st = 0; nx = m_state;
      case (m_state)
        3'd0: if (b_enter || m_pend[2]) begin nx = 4; st = 3'b100; end
              else if (m_pend[1]) begin nx = 1; st = 3'b010; end
              else if (m_pend[0]) begin nx = 1; st = 3'b001; end
              else if (!s[3]) nx = 3;
              else if (b_halt) nx = 2;
        3'd1: if (b_iret) nx = 0;
        3'd2: if (m_pend[2]) begin nx = 4; st = 3'b100; end
              else if (m_pend[1]) begin nx = 1; st = 3'b010; end
              else if (m_pend[0]) begin nx = 1; st = 3'b001; end
        3'd3: if (s[3]) nx = 0;
        3'd4: if (b_resume) nx = 0;
              else if (!s[3]) nx = 7;
              else if (b_halt) nx = 6;
        3'd5: if (b_iret) nx = 4;
        3'd6: if (m_pend[1]) begin nx = 5; st = 3'b010; end
              else if (m_pend[0]) begin nx = 5; st = 3'b001; end
        default: if (s[3]) nx = 4;
      endcase
      m_pend = (m_pend & ~st) | set;
      m_start = st;
      m_state = nx;
      m_prev = s[2:0];
      for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
      m_sync[0] = {b_susp_n, b_smi_n, b_nmi, b_intr};
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, {mode, ack_n, smi_p, nmi_p, intr_p, smm_st, nmi_st, intr_st},
        {m_state, ~m_state[1], m_pend, m_start});
  endtask

  task automatic step(int n, string tag);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset outputs", {ack_n, smi_p, nmi_p, intr_p, smm_st, nmi_st, intr_st}, 7'b1000000);
    rst_n = 1;
    step(2, "R1 idle after reset");

    b_halt = 1; step(1, "R3 halt entry"); b_halt = 0;
    chk("R3 halt suspend mode", mode, 2);
    chk("R2 ack low in suspend", ack_n, 0);
    b_nmi = 1; step(4, "R13 latency");
    chk("R13 still suspended", mode, 2);
    chk("R13 nmi latched", nmi_p, 1);
    step(1, "R4 nmi wake");
    chk("R4 nmi wake to isr", {mode, nmi_st, nmi_p}, {3'd1, 1'b1, 1'b0});
    b_nmi = 0;
    b_iret = 1; step(1, "R7 iret"); b_iret = 0;
    chk("R7 iret to normal", mode, 0);

    b_if = 0; b_intr = 1; step(5, "R8 masked");
    chk("R8 masked intr", {intr_p, mode}, {1'b0, 3'd0});
    b_intr = 0; step(1, "R8 idle");

    b_halt = 1; step(1, "R3 halt"); b_halt = 0;
    b_smi_n = 0; step(5, "R4 smi wake");
    chk("R4 smi wake to smm", {mode, smm_st}, {3'd4, 1'b1});
    b_smi_n = 1; b_resume = 1; step(1, "R6 resume"); b_resume = 0;
    chk("R6 resume to normal", mode, 0);

    b_susp_n = 0; step(4, "R3 pin");
    chk("R3 pin suspend", {mode, ack_n}, {3'd3, 1'b0});
    b_smi_n = 0; b_nmi = 1; step(5, "R5 latch in pin");
    chk("R5 events latched", {mode, smi_p, nmi_p}, {3'd3, 1'b1, 1'b1});
    b_susp_n = 1; b_smi_n = 1; b_nmi = 0; step(4, "R5 exit");
    chk("R5 pin exit to normal", mode, 0);
    step(1, "R9 smi first");
    chk("R9 smi served first", {mode, smm_st, smi_p, nmi_p}, {3'd4, 1'b1, 1'b0, 1'b1});
    chk("R12 nmi held in smm", mode, 4);
    b_halt = 1; step(1, "R3 smm halt"); b_halt = 0;
    chk("R3 smm halt suspend", mode, 6);
    step(1, "R12 smm halt wake");
    chk("R12 wake into smm isr", {mode, nmi_st, nmi_p}, {3'd5, 1'b1, 1'b0});
    b_iret = 1; step(1, "R7 smm iret"); b_iret = 0;
    chk("R7 iret back to smm", mode, 4);

    b_if = 1; b_intr = 1; step(5, "R12 intr in smm");
    chk("R12 intr held", {mode, intr_p}, {3'd4, 1'b1});
    b_intr = 0; b_smi_n = 0; step(5, "R11 smi in smm");
    chk("R11 smi ignored in smm", smi_p, 0);
    b_smi_n = 1;
    b_resume = 1; step(1, "R6 resume"); b_resume = 0;
    step(1, "R10 intr served");
    chk("R10 intr start clears flag", {mode, intr_st, intr_p}, {3'd1, 1'b1, 1'b0});
    b_iret = 1; step(1, "R7"); b_iret = 0;
    b_enter = 1; step(1, "R6 enter"); b_enter = 0;
    chk("R6 entry strobe", {mode, smm_st}, {3'd4, 1'b1});
    b_susp_n = 0; step(4, "R3 smm pin");
    chk("R3 smm pin suspend", {mode, ack_n}, {3'd7, 1'b0});
    b_susp_n = 1; step(4, "R12 smm pin exit");
    chk("R12 smm pin exit", mode, 4);
    b_resume = 1; step(1, "R6"); b_resume = 0;

    for (int c = 0; c < 4000; c++) begin
      b_halt   = ($urandom % 8) == 0;
      b_iret   = ($urandom % 5) == 0;
      b_enter  = ($urandom % 40) == 0;
      b_resume = ($urandom % 7) == 0;
      if (($urandom % 30) == 0) b_susp_n = ~b_susp_n;
      if (($urandom % 25) == 0) b_smi_n  = ~b_smi_n;
      if (($urandom % 6) == 0)  b_nmi    = ~b_nmi;
      if (($urandom % 6) == 0)  b_intr   = ~b_intr;
      if (($urandom % 4) == 0)  b_if     = ~b_if;
      step(1, "R2 R9 R13 random vs model");
    end
    finish_run();
  end
endmodule